// File: doc/BRIEF.md
# Transmit Bit Clock Generator

This block creates the transmit bit clock of a synchronous serial port, entirely inside the master clock domain. A programmable divider turns the master clock into a 50% duty divided level. That level is also brought out so the receive side can use it. A source selector then picks the transmit clock from one of three levels: the divided level, the receive clock level, or an external clock pin that is first synchronized.

Every clock here is a level that is sampled on master clock edges. No clock is gated. The internal transmit clock may be inverted. The copy driven onto the clock pin is never inverted. The pin can be driven all the time or only while a transfer is active. The pin is never driven when the external pin is the clock source.

Top module: `txck_clkgen`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `div_clk_lvl`, `tx_clk_lvl`, `pin_out` and `pin_oe` are all 0.
- R2: When `div_val` is 0, the divider is off and `div_clk_lvl` stays 0.
- R3: When `div_val` is D, with 1 ≤ D ≤ 4095, `div_clk_lvl` alternates between low runs and high runs of exactly D master cycles each. The period is 2·D, which gives a deepest division of 8190.
- R4: A change of `div_val` restarts the divider at the next edge. From that edge `div_clk_lvl` is low for D cycles, then high for D cycles, and so on.
- R5: `src_sel` encodes the source as 0 = divided level, 1 = receive level, 2 = external pin, 3 = reserved. Outputs are registered. With source 1 they follow `rx_clk_lvl` one cycle later. With source 0 they follow `div_clk_lvl` one cycle later.
- R6: `ext_pin_raw` passes through two synchronizer flops. With source 2, `tx_clk_lvl` follows it three cycles later.
- R7: `tx_clk_lvl` equals the selected source XOR `inv_en`, where `inv_en` is 1 to invert. `pin_out` never depends on `inv_en`.
- R8: `pin_mode` 0 drives the pin continuously. `pin_mode` 1 drives it only in cycles that follow a sample with `xfer_active` high. `pin_out` is the uninverted source while `pin_oe` is 1, and 0 otherwise.
- R9: When `src_sel` is 2, `pin_oe` is 0 in the following cycle.
- R10: With `src_sel` 3, the selected source is held low. `tx_clk_lvl` then equals `inv_en`, and `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_val | input | 12 | Divide value; 0 turns the divider off |
| src_sel | input | 2 | Transmit clock source select |
| inv_en | input | 1 | Invert internal transmit clock |
| pin_mode | input | 1 | 0 = drive pin always, 1 = only during transfer |
| xfer_active | input | 1 | A transfer is in progress |
| rx_clk_lvl | input | 1 | Receive clock level (master domain) |
| ext_pin_raw | input | 1 | Asynchronous clock pin input |
| div_clk_lvl | output | 1 | Divided clock level, shared with receive side |
| tx_clk_lvl | output | 1 | Internal transmit clock level |
| pin_out | output | 1 | Clock pin output value |
| pin_oe | output | 1 | Clock pin output enable |

## Verification
The hardest behaviour to reach from the ports is the full divider range. At the 4095 setting a single half period lasts thousands of cycles. The restart-on-change behaviour also needs a new value to arrive partway through a count. The stimulus handles this in phases. Each phase forces a new divide value, including 0, 1, odd, even, 4094 and 4095. It then runs long enough for several complete half periods, while the source, inversion, pin mode, receive level, pin input and transfer flag are drawn from a seeded random generator. Every sample is compared with run lengths and latencies computed in the bench.

// File: rtl/txck_pkg.sv
package txck_pkg;
  localparam int DIV_W = 12;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_DIV  = 2'd0,
    SRC_RX   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/txck_divider.sv
module txck_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_val,
  output logic         div_lvl
);
  logic [W-1:0] div_q;
  logic [W-1:0] cnt_q;
  logic         lvl_q;
  logic         restart;

  assign restart = (div_val != div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (restart) begin
      div_q <= div_val;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (div_q == '0) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (cnt_q == div_q - W'(1)) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign div_lvl = lvl_q;

  // R2: a settled zero setting never raises the level
  p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && div_val == '0) |=> !div_lvl);
  // R3: the counter stays inside one half period
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (cnt_q < div_q));
  // R4: a new setting restarts from a low level and zero count
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!div_lvl && cnt_q == '0));
endmodule

// File: rtl/txck_sync.sv
module txck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/txck_outstage.sv
module txck_outstage
  import txck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             inv_en,
  input  logic             pin_mode,
  input  logic             xfer_active,
  input  logic             div_lvl,
  input  logic             rx_lvl,
  input  logic             ext_lvl,
  output logic             tx_clk,
  output logic             pin_out,
  output logic             pin_oe
);
  logic src_lvl;
  logic drive;

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_DIV: src_lvl = div_lvl;
      SRC_RX:  src_lvl = rx_lvl;
      SRC_EXT: src_lvl = ext_lvl;
      default: src_lvl = 1'b0;
    endcase
  end

  assign drive = (src_e'(src_sel) != SRC_EXT) && (!pin_mode || xfer_active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_clk  <= 1'b0;
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      tx_clk  <= src_lvl ^ inv_en;
      pin_out <= drive & src_lvl;
      pin_oe  <= drive;
    end
  end

  // R9: an input pin is never driven back
  p_ext_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_EXT) |=> !pin_oe);
  // R8: gated mode outside a transfer releases the pin
  p_gated_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && !xfer_active) |=> !pin_oe);
  // R8: an undriven pin carries a low value
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);
  // R10: reserved source gives a low pin
  p_reserved_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_NONE) |=> !pin_out);
endmodule

// File: rtl/txck_clkgen.sv
module txck_clkgen
  import txck_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    div_val,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             inv_en,
  input  logic             pin_mode,
  input  logic             xfer_active,
  input  logic             rx_clk_lvl,
  input  logic             ext_pin_raw,
  output logic             div_clk_lvl,
  output logic             tx_clk_lvl,
  output logic             pin_out,
  output logic             pin_oe
);
  logic ext_sync;

  txck_divider #(.W(DW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_val (div_val),
    .div_lvl (div_clk_lvl)
  );

  txck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ext_pin_raw),
    .q_sync  (ext_sync)
  );

  txck_outstage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .inv_en      (inv_en),
    .pin_mode    (pin_mode),
    .xfer_active (xfer_active),
    .div_lvl     (div_clk_lvl),
    .rx_lvl      (rx_clk_lvl),
    .ext_lvl     (ext_sync),
    .tx_clk      (tx_clk_lvl),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe)
  );
endmodule

// File: tb/txck_clkgen_test.sv
`timescale 1ns/1ps
module txck_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div_val = '0;
  logic [1:0]  src_sel = '0;
  logic        inv_en = 1'b0;
  logic        pin_mode = 1'b0;
  logic        xfer_active = 1'b0;
  logic        rx_clk_lvl = 1'b0;
  logic        ext_pin_raw = 1'b0;
  logic        div_clk_lvl, tx_clk_lvl, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected-state tracking
  int  cur_div = 0;
  bit  exp_div_prev = 0;
  bit  ext_h1 = 0, ext_h2 = 0;

  always #2 clk = ~clk;

  txck_clkgen uut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .src_sel(src_sel),
    .inv_en(inv_en), .pin_mode(pin_mode), .xfer_active(xfer_active),
    .rx_clk_lvl(rx_clk_lvl), .ext_pin_raw(ext_pin_raw),
    .div_clk_lvl(div_clk_lvl), .tx_clk_lvl(tx_clk_lvl),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_div_lvl(input int d, input int j);
    if (d == 0) return 1'b0;
    return ((j / d) % 2) == 1;
  endfunction

  function automatic bit exp_src(input int sel, input bit dv, input bit rx, input bit ex);
    case (sel)
      0: return dv;
      1: return rx;
      2: return ex;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string src_tag(input int sel);
    case (sel)
      0: return "R5 div source";
      1: return "R5 rx source";
      2: return "R6 ext source";
      default: return "R10 reserved source";
    endcase
  endfunction

  // one phase: new divide value, then n cycles of checks
  task automatic run_phase(input int d, input int sel, input bit inv, input bit mode,
                           input int n, input bit rnd_sel);
    int dd = d;
    if (dd == cur_div) dd = dd ^ 1;
    cur_div = dd;
    for (int j = 0; j < n; j++) begin
      bit rx, ex, xf, src, oe, ev;
      int s;
      s  = rnd_sel ? int'($urandom_range(0, 3)) : sel;
      rx = 1'($urandom_range(0, 1));
      ex = 1'($urandom_range(0, 1));
      xf = 1'($urandom_range(0, 1));
      div_val = 12'(dd); src_sel = 2'(s); inv_en = inv; pin_mode = mode;
      xfer_active = xf; rx_clk_lvl = rx; ext_pin_raw = ex;
      @(posedge clk); #1;
      ev  = exp_div_lvl(dd, j);
      if (dd == 0) chk("R2 divider off", div_clk_lvl, 0);
      else if (j == 0) chk("R4 restart low", div_clk_lvl, ev);
      else chk("R3 divided level", div_clk_lvl, ev);
      src = exp_src(s, exp_div_prev, rx, ext_h2);
      oe  = (s != 2) && (!mode || xf);
      chk({src_tag(s), " / R7 tx"}, tx_clk_lvl, src ^ inv);
      if (s == 2) chk("R9 no drive on ext", pin_oe, 0);
      else chk("R8 pin enable", pin_oe, oe);
      chk("R8 R7 pin value", pin_out, oe ? src : 1'b0);
      exp_div_prev = ev;
      ext_h2 = ext_h1;
      ext_h1 = ex;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset div", div_clk_lvl, 0);
    chk("R1 reset tx", tx_clk_lvl, 0);
    chk("R1 reset pin", pin_out, 0);
    chk("R1 reset oe", pin_oe, 0);
    rst_n = 1'b1;
    // directed corners
    run_phase(1,    0, 0, 0, 40, 0);   // becomes 1 (from 0)
    run_phase(1,    0, 1, 0, 20, 0);   // becomes 0: off, inverted
    run_phase(3,    0, 0, 1, 60, 0);   // odd
    run_phase(4,    1, 1, 0, 60, 0);   // even, rx source
    run_phase(5,    2, 0, 0, 60, 0);   // ext source
    run_phase(6,    3, 1, 0, 30, 0);   // reserved
    run_phase(7,    0, 0, 0, 10, 0);   // change mid-count
    run_phase(4095, 0, 0, 0, 4095 * 2 + 20, 0);
    run_phase(4094, 0, 1, 1, 4094 * 3 + 5, 0);
    // constrained random phases
    for (int p = 0; p < 40; p++) begin
      run_phase(int'($urandom_range(0, 15)), 0, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), int'($urandom_range(20, 80)), 1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule